// File: doc/BRIEF.md
# Banked GPIO Controller with Write-One Set and Clear

This block is a memory-mapped general-purpose I/O controller for several banks of 32 pins. A synchronous register bus selects a register kind and a bank with one word address. Software sets each pin's direction, reads the level of each pin, and drives output pins high or low. Outputs are driven through a set register and a clear register that take a write-one mask, so no read-modify-write of the output state is ever needed.

Registers are grouped by kind, and each kind occupies a 16-byte window. Inside that window the banks follow one another at a 4-byte stride. The byte address of a register is therefore its kind offset plus four times the bank index. The kind offsets are:

- direction at 0x00
- polarity at 0x10
- data at 0x20
- set at 0x30
- clear at 0x40

Pin inputs pass through a two-flop synchroniser before software can read them. The output-enable vector follows the direction register. The polarity register is stored for the interrupt logic that sits beside this block and has no effect on the pins.

Top module: `gpio_banked`

## Requirements
- R1: After reset, every direction, polarity and output latch bit is 0. pin_oe and pin_out are all zero, and with pin_in at zero every readable register reads 0.
- R2: word_addr[5:2] selects the kind: 0 direction, 1 polarity, 2 data, 3 set, 4 clear. word_addr[1:0] selects the bank, and byte address = 4 × word_addr. Pin n of bank b is bit b*32+n of pin_in, pin_out and pin_oe, and bit n of that bank's registers.
- R3: A write to the direction register replaces the bank's direction bits, where 1 means output and 0 means input, and a read returns them. The bank's slice of pin_oe equals its direction bits.
- R4: A write to the set register sets every latch bit written as 1 and leaves bits written as 0 unchanged. This applies whatever the pin direction. The latch appears on pin_out.
- R5: A write to the clear register clears every latch bit written as 1 and leaves bits written as 0 unchanged.
- R6: The data register returns, bit by bit, the latch value for output pins and the synchronised pin_in level for input pins.
- R7: A change on pin_in first appears in rd_data three rising edges after it is applied: two synchroniser flops plus the read register.
- R8: rd_data is registered. It shows the register addressed at the previous rising edge.
- R9: A bank index of 3 or more reads 0 for every kind, and writes to it change no state.
- R10: The polarity register holds whatever is written and reads it back. It has no effect on pin_out or pin_oe.
- R11: Reads of the set and clear registers, and of kinds 5 to 15, return 0. Writes to the data register and to kinds 5 to 15 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_addr | input | 6 | Word address: kind in [5:2], bank in [1:0] |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| pin_in | input | 96 | Pin input levels, bank-major |
| pin_out | output | 96 | Output latch values |
| pin_oe | output | 96 | Output enables, 1 drives the pad |

## Verification
A corrupted latch bit shows on pin_out at the falling edge right after the faulty write. A wrong direction bit shows on pin_oe just as soon. Both are swept with a walking one in every bank, so a wrong bank or bit mapping is caught on the first misplaced bit. A synchroniser that is one stage short or one stage long is exposed by sampling the data register exactly at the second and third edges after a pin change. A bad decode is caught by the zero reads of unmapped slots and kinds, and by the pins staying unchanged after writes to those slots and kinds.

// File: rtl/gpio_banked_pkg.sv
package gpio_banked_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned WADR_W = 6;

    typedef enum logic [3:0] {
        KIND_DIR  = 4'h0,
        KIND_POL  = 4'h1,
        KIND_DATA = 4'h2,
        KIND_SET  = 4'h3,
        KIND_CLR  = 4'h4
    } reg_kind_e;

    typedef struct packed {
        logic [BUS_W-1:0] dir;
        logic [BUS_W-1:0] pol;
        logic [BUS_W-1:0] lat;
    } bank_state_t;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned W      = 96,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_banked_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [3:0]       kind,
    input  logic [BUS_W-1:0] wdata,
    input  logic [BUS_W-1:0] pin_sync,
    output bank_state_t      st_q,
    output logic [BUS_W-1:0] data_view
);
    bank_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            case (kind)
                KIND_DIR: st_d.dir = wdata;
                KIND_POL: st_d.pol = wdata;
                KIND_SET: st_d.lat = st_q.lat | wdata;
                KIND_CLR: st_d.lat = st_q.lat & ~wdata;
                default:  ;
            endcase
        end
        data_view = (st_q.dir & st_q.lat) | (~st_q.dir & pin_sync);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: written ones become set
    p_set_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && kind == KIND_SET) |=> ((st_q.lat & $past(wdata)) == $past(wdata)));

    // R4: zeros in the mask keep their latch value
    p_set_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && kind == KIND_SET) |=> (((st_q.lat ^ $past(st_q.lat)) & ~$past(wdata)) == '0));

    // R5: written ones become cleared
    p_clr_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && kind == KIND_CLR) |=> ((st_q.lat & $past(wdata)) == '0));

    // R3: direction only moves on a direction write
    p_dir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hit && kind == KIND_DIR) |=> $stable(st_q.dir));

    // R10: polarity only moves on a polarity write
    p_pol_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hit && kind == KIND_POL) |=> $stable(st_q.pol));

endmodule

// File: rtl/gpio_banked.sv
module gpio_banked
    import gpio_banked_pkg::*;
#(
    parameter int unsigned NUM_BANKS   = 3,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned PINS       = NUM_BANKS * BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WADR_W-1:0] word_addr,
    input  logic              wr_en,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [BUS_W-1:0]  rd_data,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe
);
    logic [3:0]       kind;
    logic [1:0]       slot;
    logic             slot_ok;
    logic [PINS-1:0]  pin_sync;
    bank_state_t      bank_st   [NUM_BANKS];
    logic [BUS_W-1:0] bank_data [NUM_BANKS];
    logic [BUS_W-1:0] rd_d, rd_q;

    assign kind    = word_addr[5:2];
    assign slot    = word_addr[1:0];
    assign slot_ok = (32'(slot) < NUM_BANKS);

    gpio_in_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = wr_en && slot_ok && (32'(slot) == b);

        gpio_bank_regs u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_hit    (hit),
            .kind      (kind),
            .wdata     (wr_data),
            .pin_sync  (pin_sync[b*BUS_W +: BUS_W]),
            .st_q      (bank_st[b]),
            .data_view (bank_data[b])
        );

        assign pin_out[b*BUS_W +: BUS_W] = bank_st[b].lat;
        assign pin_oe [b*BUS_W +: BUS_W] = bank_st[b].dir;
    end

    always_comb begin
        rd_d = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (slot_ok && 32'(slot) == b) begin
                case (kind)
                    KIND_DIR:  rd_d = bank_st[b].dir;
                    KIND_POL:  rd_d = bank_st[b].pol;
                    KIND_DATA: rd_d = bank_data[b];
                    default:   rd_d = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    // R9: an unmapped bank reads zero
    p_oob_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_ok |=> (rd_data == '0));

    // R9: a write to an unmapped bank leaves all pins alone
    p_oob_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !slot_ok) |=> ($stable(pin_out) && $stable(pin_oe)));

    // R11: the write-only registers read zero
    p_wo_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == KIND_SET || kind == KIND_CLR) |=> (rd_data == '0));

    // R11: a data write changes no pin
    p_data_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == KIND_DATA) |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

// File: tb/gpio_banked_test.sv
`timescale 1ns/1ps
module gpio_banked_test;
    localparam int NB = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  word_addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [95:0] pin_in = '0;
    logic [95:0] pin_out, pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] mdir [NB];
    logic [31:0] mpol [NB];
    logic [31:0] mlat [NB];

    always #2.5 clk = ~clk;

    gpio_banked uut (
        .clk(clk), .rst_n(rst_n), .word_addr(word_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] k, input int b, input logic [31:0] v);
        @(negedge clk);
        word_addr = {k, 2'(b)};
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        if (b < NB) begin
            case (k)
                4'h0: mdir[b] = v;
                4'h1: mpol[b] = v;
                4'h3: mlat[b] = mlat[b] | v;
                4'h4: mlat[b] = mlat[b] & ~v;
                default: ;
            endcase
        end
    endtask

    task automatic rd(input logic [3:0] k, input int b, output logic [31:0] v);
        @(negedge clk);
        word_addr = {k, 2'(b)};
        wr_en = 1'b0;
        @(negedge clk);
        v = rd_data;
    endtask

    function automatic logic [31:0] exp_data(input int b);
        return (mdir[b] & mlat[b]) | (~mdir[b] & pin_in[b*32 +: 32]);
    endfunction

    task automatic chk_pins(input string req);
        for (int b = 0; b < NB; b++) begin
            chk(req, pin_out[b*32 +: 32], mlat[b]);
            chk(req, pin_oe[b*32 +: 32], mdir[b]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] pats [5];
        pats[0] = 32'hA5A5_5A5A; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h0000_0001;
        pats[3] = 32'h8000_0000; pats[4] = 32'h1234_5678;
        for (int b = 0; b < NB; b++) begin
            mdir[b] = '0; mpol[b] = '0; mlat[b] = '0;
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk_pins("R1");
        for (int b = 0; b < NB; b++) begin
            for (int k = 0; k < 3; k++) begin
                rd(4'(k), b, v);
                chk("R1", v, 32'h0);
            end
        end

        // R2/R3: direction patterns per bank, pin_oe slice mapping
        foreach (pats[i]) begin
            for (int b = 0; b < NB; b++) begin
                wr(4'h0, b, pats[i] ^ 32'(b * 32'h0101_0101));
                chk_pins("R3");
                rd(4'h0, b, v);
                chk("R3", v, mdir[b]);
            end
        end
        wr(4'h0, 0, 32'h0000_FFFF);
        wr(4'h0, 1, 32'hFFFF_0000);
        wr(4'h0, 2, 32'h0F0F_0F0F);

        // R4/R5/R2: walking one through every bank and bit
        for (int b = 0; b < NB; b++) begin
            for (int n = 0; n < 32; n++) begin
                wr(4'h3, b, 32'h1 << n);
                chk($sformatf("R4 bank %0d bit %0d", b, n), pin_out[b*32 +: 32], mlat[b]);
            end
            chk_pins("R4");
            for (int n = 0; n < 32; n++) begin
                wr(4'h4, b, 32'h1 << n);
                chk($sformatf("R5 bank %0d bit %0d", b, n), pin_out[b*32 +: 32], mlat[b]);
            end
            chk_pins("R5");
        end
        foreach (pats[i]) begin
            wr(4'h3, i % NB, pats[i]);
            chk_pins("R4");
            wr(4'h4, (i + 1) % NB, pats[(i + 2) % 5]);
            chk_pins("R5");
        end

        // R6: mixed direction data reads
        foreach (pats[i]) begin
            @(negedge clk);
            pin_in = {pats[i], ~pats[(i + 1) % 5], pats[(i + 3) % 5] ^ 32'h5555_0000};
            repeat (4) @(negedge clk);
            for (int b = 0; b < NB; b++) begin
                rd(4'h2, b, v);
                chk("R6", v, exp_data(b));
            end
        end

        // R7/R8: input latency and registered read
        wr(4'h0, 0, 32'h0);
        @(negedge clk);
        pin_in[31:0] = 32'h1111_2222;
        word_addr = {4'h2, 2'd0};
        repeat (4) @(negedge clk);
        chk("R7", rd_data, 32'h1111_2222);
        pin_in[31:0] = 32'hCAFE_0B0E;
        @(negedge clk);
        chk("R7 edge1", rd_data, 32'h1111_2222);
        @(negedge clk);
        chk("R7 edge2", rd_data, 32'h1111_2222);
        @(negedge clk);
        chk("R7 edge3", rd_data, 32'hCAFE_0B0E);
        word_addr = {4'h0, 2'd1};
        #1;
        chk("R8 before edge", rd_data, 32'hCAFE_0B0E);
        @(negedge clk);
        chk("R8 after edge", rd_data, mdir[1]);

        // R10: polarity storage without pin effect
        foreach (pats[i]) begin
            for (int b = 0; b < NB; b++) begin
                wr(4'h1, b, pats[i] + 32'(b));
                chk_pins("R10");
                rd(4'h1, b, v);
                chk("R10", v, mpol[b]);
            end
        end

        // R9: bank slot 3
        for (int k = 0; k < 16; k++) begin
            wr(4'(k), 3, 32'hFFFF_FFFF);
            chk_pins("R9");
            rd(4'(k), 3, v);
            chk("R9", v, 32'h0);
        end
        for (int b = 0; b < NB; b++) begin
            rd(4'h1, b, v);
            chk("R9 pol kept", v, mpol[b]);
        end

        // R11: write-only and unused kinds
        for (int b = 0; b < NB; b++) begin
            for (int k = 3; k < 16; k++) begin
                rd(4'(k), b, v);
                chk("R11", v, 32'h0);
            end
            wr(4'h2, b, 32'hFFFF_FFFF);
            chk_pins("R11");
            for (int k = 5; k < 16; k++) wr(4'(k), b, 32'hFFFF_FFFF);
            chk_pins("R11");
            rd(4'h1, b, v);
            chk("R11 pol kept", v, mpol[b]);
            rd(4'h2, b, v);
            chk("R11 data", v, exp_data(b));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule